// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers a small set of asynchronous event lines into one host interrupt request. Each line has its own enable bit and its own sticky status bit. Every line is first brought into the clock domain and then watched for a low-to-high transition. When such a transition arrives on an enabled line, the status bit for that line latches to one. It stays at one until software turns the line's enable bit off. There is no separate acknowledge register: writing zero to an enable bit is the only way to clear the matching status bit.

The request output is a level. It rises in the cycle in which the status register leaves the all-zero state. It stays high while any status bit is set, even when more bits are latched. Only after the whole register has returned to zero can a new request be raised. Software reaches the enable register and the status register through a simple single-cycle register bus: a write strobe, an address and write data, plus a combinational read-data path.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the enable register, the status register and `irq_o` all read as zero.
- R2: A rising edge on `src_i[i]` while enable bit i is set makes status bit i read as one after the third rising clock edge, counting from the edge that first samples the new level. It reads as zero after the second edge. This covers the two-flop synchroniser plus the edge register.
- R3: A set status bit stays set while its enable bit stays set, whatever the source does afterwards.
- R4: A status bit is cleared by writing zero to its enable bit (address 0). A write to the status address (address 1) changes neither register.
- R5: A rising edge that reaches the edge detector while the enable bit is clear is ignored. This holds even if the enable is written to one in that same cycle or any later cycle.
- R6: If a write clears an enable bit in the same cycle that the bit's edge would set status, the status bit ends up zero.
- R7: `irq_o` rises in the same cycle in which the status register goes from all-zero to non-zero.
- R8: `irq_o` stays high while the status register is non-zero. Additional status bits cause no new rising edge on `irq_o`. `irq_o` falls in the cycle the status register returns to zero.
- R9: Reads return the enable register at address 0 and the status register at address 1. Any other address reads as zero.
- R10: A source held high sets no status bit when its enable bit is turned on again; only a new low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Raw asynchronous event lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 enable, 1 status) |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt request |

## Verification
The embedded properties check, on every cycle, several invariants. No status bit may be set while its enable is clear. Set bits persist while enabled. A bit can only become newly set if it was enabled in the previous cycle. A write that clears an enable leaves the matching status bit zero one cycle later. The request always matches a non-zero status, and it only rises out of an all-zero register. The synchroniser latency, the ignored edges on disabled or still-high lines, the same-cycle clear priority, the rejected status-address write and the single request edge across several latched bits all depend on stimulus order. Only the bench scenarios show those, together with a full sweep of every enable mask against every source pattern.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
   localparam int unsigned SEL_ENABLE = 0;
   localparam int unsigned SEL_STATUS = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_i[gi]};
      end
      assign q_o[gi] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/irq_edge.sv
module irq_edge #(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~last_q;

   // R2: a detected rise is never two cycles wide
   assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_status.sv
module irq_status #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  rise_i,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  en_o,
   output logic [WIDTH-1:0]  stat_o,
   output logic [WIDTH-1:0]  stat_next_o
);
   import edge_irq_pkg::*;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("irq_status: ADDR_W must be at least 1");
   end

   logic [WIDTH-1:0] en_q, en_d, stat_q;
   logic             en_wr;

   assign en_wr = bus_wr && (bus_addr == ADDR_W'(SEL_ENABLE));
   assign en_d  = en_wr ? bus_wdata : en_q;

   // a new edge only counts against the enable already in force;
   // the enable taking effect this edge masks everything, so clear wins
   assign stat_next_o = en_d & (stat_q | (rise_i & en_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         stat_q <= '0;
      end else begin
         en_q   <= en_d;
         stat_q <= stat_next_o;
      end
   end

   assign en_o   = en_q;
   assign stat_o = stat_q;

   // R4: status never holds a bit whose enable is clear
   assert_stat_within_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~en_q) == '0);
   // R3: set bits persist while enable stays on
   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(stat_q) & $past(en_q) & en_q & ~stat_q) == '0));
   // R5: a bit can only become set if it was enabled a cycle earlier
   assert_set_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));
   // R6: clearing write leaves those status bits zero
   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> ((stat_q & ~$past(bus_wdata)) == '0));
endmodule

// File: rtl/irq_req.sv
module irq_req #(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] stat_next_i,
   input  logic [WIDTH-1:0] stat_i,
   output logic             irq_o
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |stat_next_i;
   end

   assign irq_o = irq_q;

   // R8: request level tracks a non-zero status register
   assert_level_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q == (stat_i != '0));
   // R7: request only rises out of an all-zero status register
   assert_rise_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> ($past(stat_i) == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
   parameter int unsigned N_SRC       = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_SRC-1:0]  bus_wdata,
   output logic [N_SRC-1:0]  bus_rdata,
   output logic              irq_o
);
   import edge_irq_pkg::*;

   if (N_SRC < 1 || N_SRC > 32) begin : g_bad_nsrc
      $error("edge_irq_ctrl: N_SRC must be 1..32");
   end

   logic [N_SRC-1:0] src_sync, src_rise, en_w, stat_w, stat_next_w;

   irq_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(src_sync));

   irq_edge #(.WIDTH(N_SRC)) edge_i (
      .clk(clk), .rst_n(rst_n), .lvl_i(src_sync), .rise_o(src_rise));

   irq_status #(.WIDTH(N_SRC), .ADDR_W(ADDR_W)) status_i (
      .clk(clk), .rst_n(rst_n), .rise_i(src_rise),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .en_o(en_w), .stat_o(stat_w), .stat_next_o(stat_next_w));

   irq_req #(.WIDTH(N_SRC)) req_i (
      .clk(clk), .rst_n(rst_n), .stat_next_i(stat_next_w),
      .stat_i(stat_w), .irq_o(irq_o));

   always_comb begin
      if (bus_addr == ADDR_W'(SEL_ENABLE))      bus_rdata = en_w;
      else if (bus_addr == ADDR_W'(SEL_STATUS)) bus_rdata = stat_w;
      else                                      bus_rdata = '0;
   end

   // R9: unmapped addresses read as zero
   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > ADDR_W'(SEL_STATUS)) |-> (bus_rdata == '0));
endmodule

// File: tb/edge_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module edge_irq_ctrl_tb_top;
   localparam int N = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] src_i = '0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [N-1:0] bus_wdata = '0;
   logic [N-1:0] bus_rdata;
   logic irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   int irq_rises = 0;
   logic irq_last = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   edge_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o));

   task automatic step();
      @(posedge clk);
      #0.5;
      if (irq_o && !irq_last) irq_rises++;
      irq_last = irq_o;
   endtask

   task automatic steps(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = N'(d);
      step();
      bus_wr = 1'b0; bus_addr = 2'd0;
   endtask

   task automatic rd(input int a, output int d);
      bus_addr = 2'(a);
      #0.5;
      d = int'(bus_rdata);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      int base;
      steps(3);
      // R1 reset state
      rd(0, v); chk("R1 enable", v, 0);
      rd(1, v); chk("R1 status", v, 0);
      chk("R1 irq", int'(irq_o), 0);
      rst_n = 1'b1;
      step();

      // sweep: every enable mask against every source pattern (R2 R3 R4 R7)
      for (int e = 0; e < 64; e++) begin
         for (int p = 0; p < 64; p++) begin
            wr(0, e);
            src_i = N'(p);
            steps(2);
            rd(1, v); chk("R2 latency", v, 0);
            step();
            rd(1, v); chk("R2 latch", v, e & p);
            chk("R7 irq", int'(irq_o), ((e & p) != 0) ? 1 : 0);
            src_i = '0;
            steps(3);
            rd(1, v); chk("R3 sticky", v, e & p);
            wr(0, 0);
            rd(1, v); chk("R4 clear", v, 0);
            chk("R8 irq drop", int'(irq_o), 0);
         end
      end

      // R5: edge while disabled, enabled later
      src_i = 6'b000001; steps(3);
      wr(0, 1); steps(2);
      rd(1, v); chk("R5 late enable", v, 0);
      src_i = '0; steps(3); wr(0, 0);
      // R5: enable written in the cycle the edge is detected
      src_i = 6'b000010; steps(2);
      wr(0, 2);
      rd(1, v); chk("R5 same-cycle enable", v, 0);
      step(); rd(1, v); chk("R5 stays clear", v, 0);
      src_i = '0; steps(3); wr(0, 0);

      // R6: clear in the cycle the edge would set
      wr(0, 4);
      src_i = 6'b000100; steps(2);
      wr(0, 0);
      rd(1, v); chk("R6 clear priority", v, 0);
      chk("R6 irq", int'(irq_o), 0);
      // R10: held-high source after re-enable
      wr(0, 4); steps(4);
      rd(1, v); chk("R10 held high", v, 0);
      chk("R10 irq", int'(irq_o), 0);
      src_i = '0; steps(3); wr(0, 0);

      // R8: one request edge across several bits
      wr(0, 3);
      base = irq_rises;
      src_i = 6'b000001; steps(3);
      chk("R7 irq up", int'(irq_o), 1);
      src_i = 6'b000011; steps(3);
      rd(1, v); chk("R8 both bits", v, 3);
      chk("R8 single rise", irq_rises - base, 1);
      // R4: write to status address ignored
      wr(1, 0);
      rd(1, v); chk("R4 status write ignored", v, 3);
      rd(0, v); chk("R4 enable untouched", v, 3);
      wr(0, 2);
      rd(1, v); chk("R8 partial clear", v, 2);
      chk("R8 irq held", int'(irq_o), 1);
      wr(0, 0);
      chk("R8 irq low", int'(irq_o), 0);
      src_i = '0; steps(3);
      wr(0, 1);
      src_i = 6'b000001; steps(3);
      chk("R8 refire", int'(irq_o), 1);
      chk("R8 second rise", irq_rises - base, 2);

      // R9 readback
      rd(0, v); chk("R9 enable read", v, 1);
      rd(2, v); chk("R9 addr2 zero", v, 0);
      rd(3, v); chk("R9 addr3 zero", v, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule